// File: doc/BRIEF.md
# Byte-Wide Parallel Configuration Port

This block is the device-side receiver for a byte-wide configuration load driven by an external agent. The agent supplies the configuration clock, an active-low select, an active-low write strobe and an 8-bit data bus. On every rising clock edge where select and write are both low and the port is not stalled, the byte on the bus is taken. The bus carries its most significant bit on line 0, so the port reverses the bit order before passing the byte on. Accepted bytes leave through a single-entry valid/ready register toward the downstream frame loader.

The port drives a stall flag back to the agent. The flag is high whenever the downstream side is not ready, and the agent must hold its byte until an edge where the flag is low. Releasing the write strobe while select stays low cancels the running write sequence. The port then runs a fixed flush of `FLUSH_CYCLES` clocks with the stall flag high, and sets a sticky abort flag. That flag stays set until the next write sequence starts. Releasing select ends a sequence normally.

The controller has three states:
- `PP_IDLE`: no write sequence is running.
- `PP_WRITE`: a write sequence is in progress.
- `PP_FLUSH`: an abort is being drained.

It has five transitions:
- start: `PP_IDLE` to `PP_WRITE` when select and write are both low.
- finish: `PP_WRITE` to `PP_IDLE` when select goes high.
- cancel: `PP_WRITE` to `PP_FLUSH` when write goes high while select stays low.
- drain-done: `PP_FLUSH` to `PP_IDLE` after the last flush cycle.
- stay: every other case keeps the current state.

Top module: `cfg_parport`

## Requirements
- R1: After reset, `dout_valid` and `abort_seen` are 0 and the controller is idle.
- R2: On a rising edge where `cs_n`=0, `wr_n`=0 and `busy`=0, a byte is accepted. `dout_valid` is 1 after that edge.
- R3: An accepted byte appears on `dout` bit-reversed: `dout[7-i]` equals `din[i]`, because `din[0]` carries the MSB.
- R4: `busy` is 1 in every cycle where `dout_ready` is 0. No byte is accepted on an edge where `busy` is 1. A held byte is accepted on the first edge where `busy` is 0.
- R5: While `dout_valid`=1 and `dout_ready`=0, `dout_valid` and `dout` stay unchanged. `dout_valid` falls after an edge with `dout_ready`=1 and no new acceptance.
- R6: Setting `wr_n`=1 while `cs_n`=0 during a write sequence starts an abort at that edge. `busy` then stays 1 for exactly `FLUSH_CYCLES` (4) cycles, and no byte is accepted during them.
- R7: An abort sets `abort_seen` to 1. The flag stays 1 until the edge that starts the next write sequence (`cs_n`=0 and `wr_n`=0 from idle), which clears it.
- R8: With `cs_n`=1 no byte is accepted, whatever `wr_n` is. Raising `cs_n` ends a sequence without setting `abort_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock from the agent; rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Data bus, MSB on bit 0 |
| busy | output | 1 | Stall flag to the agent |
| dout | output | 8 | Accepted byte, normal bit order |
| dout_valid | output | 1 | `dout` holds a byte |
| dout_ready | input | 1 | Downstream can take `dout` |
| abort_seen | output | 1 | Sticky flag: last sequence was aborted |

## Verification
The bench builds the port with its defaults: an 8-bit bus and a 4-cycle flush. With a flush this short, aborts happen many times within a few thousand random cycles. As a result, the random stream keeps hitting aborts that land while a byte waits for a stalled downstream side, and new sequences that start right after a flush. Random `dout_ready` drops put the stall-then-accept path under constant pressure. Directed runs then count the flush length and confirm that bytes are ignored while select is high.

// File: rtl/cfg_parport_pkg.sv
package cfg_parport_pkg;

    typedef enum logic [1:0] {
        PP_IDLE  = 2'd0,
        PP_WRITE = 2'd1,
        PP_FLUSH = 2'd2
    } pp_state_e;

endpackage

// File: rtl/cfg_parport_bitrev.sv
module cfg_parport_bitrev #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] word_out
);

    // Line 0 of the bus carries the MSB; flip into normal order.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign word_out[DATA_W-1-i] = bus_in[i];
    end

endmodule

// File: rtl/cfg_parport_flushcnt.sv
module cfg_parport_flushcnt #(
    parameter int FLUSH_CYCLES = 4
) (
    input  logic cclk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    output logic done
);

    localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FLUSH_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (active && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = active && (cnt == LAST);

endmodule

// File: rtl/cfg_parport_fsm.sv
module cfg_parport_fsm
    import cfg_parport_pkg::*;
(
    input  logic cclk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic sink_ready,
    input  logic flush_done,
    output logic busy,
    output logic accept,
    output logic abort_req,
    output logic flushing,
    output logic abort_seen
);

    pp_state_e state, state_nx;
    logic      seq_start;

    // State register
    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PP_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Sticky abort status
    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) begin
            abort_seen <= 1'b0;
        end else if (abort_req) begin
            abort_seen <= 1'b1;
        end else if (seq_start) begin
            abort_seen <= 1'b0;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            PP_IDLE: begin
                if (!cs_n && !wr_n) state_nx = PP_WRITE;
            end
            PP_WRITE: begin
                if (cs_n)      state_nx = PP_IDLE;
                else if (wr_n) state_nx = PP_FLUSH;
            end
            PP_FLUSH: begin
                if (flush_done) state_nx = PP_IDLE;
            end
            default: state_nx = PP_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        flushing  = (state == PP_FLUSH);
        busy      = flushing || !sink_ready;
        accept    = !cs_n && !wr_n && !busy;
        seq_start = (state == PP_IDLE) && !cs_n && !wr_n;
        abort_req = (state == PP_WRITE) && !cs_n && wr_n;
    end

endmodule

// File: rtl/cfg_parport_outreg.sv
module cfg_parport_outreg #(
    parameter int DATA_W = 8
) (
    input  logic              cclk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              ready,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_data;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/cfg_parport.sv
module cfg_parport #(
    parameter int DATA_W       = 8,
    parameter int FLUSH_CYCLES = 4
) (
    input  logic              cclk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    input  logic              dout_ready,
    output logic              abort_seen
);

    logic              accept;
    logic              abort_req;
    logic              flushing;
    logic              flush_done;
    logic [DATA_W-1:0] din_rev;

    cfg_parport_fsm u_fsm (
        .cclk       (cclk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .wr_n       (wr_n),
        .sink_ready (dout_ready),
        .flush_done (flush_done),
        .busy       (busy),
        .accept     (accept),
        .abort_req  (abort_req),
        .flushing   (flushing),
        .abort_seen (abort_seen)
    );

    cfg_parport_flushcnt #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_flush (
        .cclk   (cclk),
        .rst_n  (rst_n),
        .start  (abort_req),
        .active (flushing),
        .done   (flush_done)
    );

    cfg_parport_bitrev #(.DATA_W(DATA_W)) u_rev (
        .bus_in   (din),
        .word_out (din_rev)
    );

    cfg_parport_outreg #(.DATA_W(DATA_W)) u_out (
        .cclk      (cclk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (din_rev),
        .ready     (dout_ready),
        .valid     (dout_valid),
        .data      (dout)
    );

endmodule

// File: rtl/cfg_parport_chk.sv
module cfg_parport_chk #(
    parameter int DATA_W = 8
) (
    input logic              cclk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_n,
    input logic              busy,
    input logic [DATA_W-1:0] dout,
    input logic              dout_valid,
    input logic              dout_ready,
    input logic              abort_seen
);

    // R4: with downstream stalled, an empty output stays empty
    assert_no_accept_stalled_R4: assert property (@(posedge cclk) disable iff (!rst_n)
        (!dout_ready && !dout_valid) |=> !dout_valid);

    // R5: a waiting byte is held stable
    assert_hold_R5: assert property (@(posedge cclk) disable iff (!rst_n)
        (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout)));

    // R8: select high takes nothing in
    assert_no_accept_deselected_R8: assert property (@(posedge cclk) disable iff (!rst_n)
        (cs_n && (!dout_valid || dout_ready)) |=> !dout_valid);

    // R6: the abort edge is followed by a stalled cycle
    assert_abort_stall_R6: assert property (@(posedge cclk) disable iff (!rst_n)
        $rose(abort_seen) |-> busy);

    // R7: the flag only rises from an abort request (select low, write high)
    assert_flag_source_R7: assert property (@(posedge cclk) disable iff (!rst_n)
        $rose(abort_seen) |-> $past(!cs_n && wr_n));

    // R1: reset state
    always_ff @(posedge cclk) begin
        if (!rst_n) begin
            assert_reset_R1: assert (!dout_valid && !abort_seen);
        end
    end

endmodule

bind cfg_parport cfg_parport_chk #(.DATA_W(DATA_W)) u_chk (
    .cclk       (cclk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .wr_n       (wr_n),
    .busy       (busy),
    .dout       (dout),
    .dout_valid (dout_valid),
    .dout_ready (dout_ready),
    .abort_seen (abort_seen)
);

// File: tb/cfg_parport_bench.sv
`timescale 1ns/1ps
module cfg_parport_bench;

    localparam int FLUSH = 4;

    logic       cclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] din = '0;
    logic       busy;
    logic [7:0] dout;
    logic       dout_valid;
    logic       dout_ready = 1'b1;
    logic       abort_seen;

    int vectors = 0;
    int errors  = 0;
    bit done_flag = 0;

    // model state: 0 idle, 1 write, 2 flush
    int       m_st  = 0;
    int       m_cnt = 0;
    bit       m_val = 0;
    bit [7:0] m_dat = '0;
    bit       m_abt = 0;

    always #2 cclk = ~cclk;

    cfg_parport u_cfg_parport (
        .cclk(cclk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .din(din),
        .busy(busy), .dout(dout), .dout_valid(dout_valid),
        .dout_ready(dout_ready), .abort_seen(abort_seen)
    );

    function automatic bit [7:0] rev8(input bit [7:0] v);
        bit [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = v[i];
        return r;
    endfunction

    function automatic bit exp_busy(input int st, input bit rdy);
        return (st == 2) || !rdy;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_regs();
        chk("R2 dout_valid", {7'b0, dout_valid}, {7'b0, m_val});
        if (m_val) chk("R3 dout", dout, m_dat);
        chk("R7 abort_seen", {7'b0, abort_seen}, {7'b0, m_abt});
    endtask

    task automatic model_edge(input bit c, input bit w, input bit [7:0] d, input bit r);
        bit acc;
        acc = (m_st != 2) && !c && !w && !exp_busy(m_st, r);
        if (acc) begin
            m_val = 1; m_dat = rev8(d);
        end else if (r) begin
            m_val = 0;
        end
        case (m_st)
            0: if (!c && !w) begin m_st = 1; m_abt = 0; end
            1: if (c) m_st = 0;
               else if (w) begin m_st = 2; m_cnt = 0; m_abt = 1; end
            default: if (m_cnt == FLUSH - 1) m_st = 0; else m_cnt++;
        endcase
    endtask

    task automatic step(input bit c, input bit w, input bit [7:0] d, input bit r);
        @(negedge cclk);
        check_regs();
        cs_n = c; wr_n = w; din = d; dout_ready = r;
        #0.5;
        chk("R4 busy", {7'b0, busy}, {7'b0, exp_busy(m_st, r)});
        model_edge(c, w, d, r);
    endtask

    initial begin
        #(4 * 200000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int busy_run;
        void'($urandom(32'd1234));
        repeat (3) @(negedge cclk);
        chk("R1 dout_valid", {7'b0, dout_valid}, 8'h0);
        chk("R1 abort_seen", {7'b0, abort_seen}, 8'h0);
        rst_n = 1'b1;

        // R2/R3: directed byte with distinct bit pattern
        step(0, 0, 8'h01, 1);
        step(0, 0, 8'hA5, 1);
        step(1, 1, 8'h00, 1);
        step(1, 1, 8'h00, 1);

        // R4/R5: stall with held byte, then release
        step(0, 0, 8'h3C, 1);
        step(0, 0, 8'h0F, 0);
        step(0, 0, 8'h0F, 0);
        step(0, 0, 8'h0F, 1);
        step(1, 1, 8'h00, 1);

        // R8: select high, write low: nothing accepted
        step(1, 0, 8'hFF, 1);
        step(1, 0, 8'hFF, 1);
        @(negedge cclk);
        chk("R8 dout_valid", {7'b0, dout_valid}, 8'h0);
        chk("R8 abort_seen", {7'b0, abort_seen}, 8'h0);
        cs_n = 1; wr_n = 1;
        model_edge(1, 1, 8'h00, 1);

        // R6: abort, count stalled cycles with ready high
        step(0, 0, 8'h11, 1);
        step(0, 1, 8'h22, 1);
        busy_run = 0;
        for (int k = 0; k < 8; k++) begin
            step(0, 0, 8'h33, 1);
            if (busy) busy_run++;
        end
        chk("R6 flush length", 8'(busy_run), 8'(FLUSH));
        step(1, 1, 8'h00, 1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit c, w, r;
            c = ($urandom_range(0, 9) < 2);
            w = ($urandom_range(0, 9) < 2);
            r = ($urandom_range(0, 9) < 7);
            step(c, w, 8'($urandom), r);
        end
        @(negedge cclk);
        check_regs();

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule